// File: doc/BRIEF.md
# DMA Channel Address, Count and Status

This block holds the programmable state of one memory-to-memory DMA channel and sequences its operand transfers. Software programs a 24-bit source pointer, a 24-bit destination pointer, a 16-bit byte count, a function-code register and a mode word over a simple register bus. It then sets the start bit. While the channel is busy it raises a request to an external transfer engine. With each request it presents the size of the next operand (1 or 2 bytes), the address, and a 3-bit qualifier code for the current phase.

The engine answers each read/write pair with an acknowledge, or with a source or destination bus error. It can also ask for early termination. The block advances the pointers, decrements the count and records the result in a write-one-to-clear status register. The status bits are also available as direct outputs.

Top module: `dma_chan`

Register map (3-bit word address, 24-bit data):
- 0: control. Writes use bit0 = start, bit1 = source increment, bit2 = destination increment, bit3 = 16-bit operands. Reads return the same bits, with bit0 giving busy.
- 1: source pointer.
- 2: destination pointer.
- 3: byte count.
- 4: function codes. Bits 2:0 hold the source code and bits 6:4 the destination code.
- 5: status. Bit0 DONE, bit1 BED, bit2 BES, bit3 DNS.

## Requirements
- R1: Each pointer advances by the operand size after every acknowledged transfer when its increment bit is set, and holds its value when the bit is clear. The addition is unsigned 24-bit, so 0xFFFFFF plus 1 gives 0x000000.
- R2: The operand size is 1 byte in each of these cases: byte mode, either pointer odd, or one byte remaining. It is 2 bytes only when 16-bit mode is set, both pointers are even and at least two bytes remain.
- R3: The count drops by the bytes each acknowledged transfer moves. The channel stops when the count reaches zero, so the bytes moved equal the programmed count, including odd counts in 16-bit mode.
- R4: A programmed count of 0 moves 65536 bytes.
- R5: When the final transfer is acknowledged, busy and request fall on the next cycle and DONE (status bit0) sets.
- R6: In the read phase (phase_wr_i=0) the outputs carry the source pointer and source code. In the write phase they carry the destination pointer and destination code. A write that gives a function-code field the value 111 leaves that field unchanged.
- R7: The status register has DONE in bit0, BED in bit1, BES in bit2 and DNS in bit3. Writing a 1 to a bit clears it and writing a 0 leaves it unchanged. Several bits can be cleared in one write. Bits 23:4 read as zero. Reset clears every bit.
- R8: When a status bit is set and cleared in the same cycle, it ends up set.
- R9: A source error sets BES (bit2) and a destination error sets BED (bit1). Either error stops the channel at once. Neither the pointers nor the count take the update of the failing transfer, and DONE does not set.
- R10: While busy, writes to the control, pointer and count registers have no effect.
- R11: An early-termination request that comes with the acknowledge of a transfer other than the last stops the channel after that transfer and sets DNS (bit3), not DONE.
- R12: After reset the channel is idle with no request, the status is zero, the pointers read zero and the count reads zero, meaning 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 24 | Register write data |
| reg_rdata_o | output | 24 | Register read data for reg_addr_i |
| xfer_req_o | output | 1 | Request for one operand read/write pair |
| xfer_bytes_o | output | 2 | Size of the requested operand, 1 or 2 |
| phase_wr_i | input | 1 | Engine phase: 0 read, 1 write |
| bus_addr_o | output | 24 | Address for the current phase |
| bus_fc_o | output | 3 | Function code for the current phase |
| xfer_ack_i | input | 1 | Current pair completed |
| src_err_i | input | 1 | Bus error on the read |
| dst_err_i | input | 1 | Bus error on the write |
| ext_done_i | input | 1 | Early-termination request, sampled with the acknowledge |
| busy_o | output | 1 | Channel active |
| stat_o | output | 4 | Status bits DNS, BES, BED, DONE |

## Verification
A hardware status set and a software write-one-to-clear of the same bit can fall in the same cycle. The bench provokes this by driving a source bus error in the same cycle as a write of 0xF to the status register. It judges the result by requiring BES to read back as set while the untouched bits stay clear. A second overlap comes from a register reload during an active transfer: pointer, count and start writes are issued while the engine is still being served, and the final pointer values must match those of the original programming.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_SRC  = 3'd1,
    REG_DST  = 3'd2,
    REG_CNT  = 3'd3,
    REG_FC   = 3'd4,
    REG_STAT = 3'd5
  } reg_e;

  localparam int ST_DONE = 0;
  localparam int ST_BED  = 1;
  localparam int ST_BES  = 2;
  localparam int ST_DNS  = 3;
  localparam int ST_W    = 4;
  localparam int FC_W    = 3;
  localparam logic [FC_W-1:0] FC_BAD = '1;
endpackage

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int AW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          adv_i,
  input  logic          inc_i,
  input  logic [1:0]    step_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ptr_o <= '0;
    else if (load_i)          ptr_o <= load_val_i;
    else if (adv_i && inc_i)  ptr_o <= ptr_o + AW'(step_i);  // wraps
  end
endmodule

// File: rtl/dma_cnt.sv
module dma_cnt #(
  parameter int CW = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic        dec_i,
  input  logic [1:0]  step_i,
  output logic [CW:0] rem_o
);
  localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_o <= FULL;
    else if (load_i) rem_o <= (load_val_i == '0) ? FULL : {1'b0, load_val_i};
    else if (dec_i)  rem_o <= rem_o - (CW+1)'(step_i);
  end
endmodule

// File: rtl/dma_stat.sv
module dma_stat #(
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] set_i,
  input  logic [SW-1:0] clr_i,
  output logic [SW-1:0] stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= (stat_o & ~clr_i) | set_i;  // set wins
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_addr_i,
  input  logic [AW-1:0]   reg_wdata_i,
  output logic [AW-1:0]   reg_rdata_o,
  output logic            xfer_req_o,
  output logic [1:0]      xfer_bytes_o,
  input  logic            phase_wr_i,
  output logic [AW-1:0]   bus_addr_o,
  output logic [FC_W-1:0] bus_fc_o,
  input  logic            xfer_ack_i,
  input  logic            src_err_i,
  input  logic            dst_err_i,
  input  logic            ext_done_i,
  output logic            busy_o,
  output logic [ST_W-1:0] stat_o
);
  logic [AW-1:0]   src_ptr, dst_ptr;
  logic [CW:0]     rem;
  logic            busy_q, src_inc_q, dst_inc_q, size16_q;
  logic [FC_W-1:0] src_fc_q, dst_fc_q;
  logic [1:0]      step;
  logic            wr_ctrl, wr_src, wr_dst, wr_cnt, wr_fc, wr_stat;
  logic            start, any_err, ack_ok, last, stop;
  logic [ST_W-1:0] st_set, st_clr;

  assign wr_ctrl = reg_we_i && (reg_addr_i == REG_CTRL) && !busy_q;
  assign wr_src  = reg_we_i && (reg_addr_i == REG_SRC)  && !busy_q;
  assign wr_dst  = reg_we_i && (reg_addr_i == REG_DST)  && !busy_q;
  assign wr_cnt  = reg_we_i && (reg_addr_i == REG_CNT)  && !busy_q;
  assign wr_fc   = reg_we_i && (reg_addr_i == REG_FC);
  assign wr_stat = reg_we_i && (reg_addr_i == REG_STAT);

  assign start   = wr_ctrl && reg_wdata_i[0];
  assign step    = (size16_q && !src_ptr[0] && !dst_ptr[0] && (rem > (CW+1)'(1))) ? 2'd2 : 2'd1;
  assign any_err = busy_q && (src_err_i || dst_err_i);
  assign ack_ok  = busy_q && xfer_ack_i && !src_err_i && !dst_err_i;
  assign last    = (rem == (CW+1)'(step));
  assign stop    = any_err || (ack_ok && (last || ext_done_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      src_inc_q <= 1'b0;
      dst_inc_q <= 1'b0;
      size16_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        src_inc_q <= reg_wdata_i[1];
        dst_inc_q <= reg_wdata_i[2];
        size16_q  <= reg_wdata_i[3];
      end
      if (start)     busy_q <= (rem != '0);
      else if (stop) busy_q <= 1'b0;
    end
  end

  // illegal code 111 keeps the old field
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_fc_q <= '0;
      dst_fc_q <= '0;
    end else if (wr_fc) begin
      if (reg_wdata_i[2:0] != FC_BAD) src_fc_q <= reg_wdata_i[2:0];
      if (reg_wdata_i[6:4] != FC_BAD) dst_fc_q <= reg_wdata_i[6:4];
    end
  end

  dma_ptr #(.AW(AW)) u_src (
    .clk_i, .rst_ni, .load_i(wr_src), .load_val_i(reg_wdata_i),
    .adv_i(ack_ok), .inc_i(src_inc_q), .step_i(step), .ptr_o(src_ptr)
  );

  dma_ptr #(.AW(AW)) u_dst (
    .clk_i, .rst_ni, .load_i(wr_dst), .load_val_i(reg_wdata_i),
    .adv_i(ack_ok), .inc_i(dst_inc_q), .step_i(step), .ptr_o(dst_ptr)
  );

  dma_cnt #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .load_i(wr_cnt), .load_val_i(reg_wdata_i[CW-1:0]),
    .dec_i(ack_ok), .step_i(step), .rem_o(rem)
  );

  always_comb begin
    st_set          = '0;
    st_set[ST_DONE] = (ack_ok && last) || (start && rem == '0);
    st_set[ST_BED]  = busy_q && dst_err_i;
    st_set[ST_BES]  = busy_q && src_err_i;
    st_set[ST_DNS]  = ack_ok && ext_done_i && !last;
    st_clr          = wr_stat ? reg_wdata_i[ST_W-1:0] : '0;
  end

  dma_stat #(.SW(ST_W)) u_stat (
    .clk_i, .rst_ni, .set_i(st_set), .clr_i(st_clr), .stat_o(stat_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CTRL: reg_rdata_o[3:0] = {size16_q, dst_inc_q, src_inc_q, busy_q};
      REG_SRC:  reg_rdata_o = src_ptr;
      REG_DST:  reg_rdata_o = dst_ptr;
      REG_CNT:  reg_rdata_o[CW-1:0] = rem[CW-1:0];
      REG_FC:   reg_rdata_o[7:0] = {1'b0, dst_fc_q, 1'b0, src_fc_q};
      REG_STAT: reg_rdata_o[ST_W-1:0] = stat_o;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign busy_o       = busy_q;
  assign xfer_req_o   = busy_q;
  assign xfer_bytes_o = step;
  assign bus_addr_o   = phase_wr_i ? dst_ptr : src_ptr;
  assign bus_fc_o     = phase_wr_i ? dst_fc_q : src_fc_q;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [2:0]    reg_addr_i,
  input logic [AW-1:0] reg_rdata_o,
  input logic          xfer_req_o,
  input logic [1:0]    xfer_bytes_o,
  input logic          xfer_ack_i,
  input logic          src_err_i,
  input logic          dst_err_i,
  input logic          busy_o,
  input logic [3:0]    stat_o,
  input logic [AW-1:0] src_ptr,
  input logic [AW-1:0] dst_ptr,
  input logic [CW:0]   rem,
  input logic          size16_q
);
  assert_bytes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> (xfer_bytes_o == 2'd1 || (xfer_bytes_o == 2'd2 && size16_q)));

  assert_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && xfer_ack_i && !src_err_i && !dst_err_i && rem == (CW+1)'(xfer_bytes_o))
    |=> (!busy_o && stat_o[0]));

  assert_rsvd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 3'd5) |-> (reg_rdata_o[AW-1:4] == '0));

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && src_err_i) |=> stat_o[2]);

  assert_err_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (src_err_i || dst_err_i))
    |=> (!busy_o && $stable(src_ptr) && $stable(dst_ptr) && $stable(rem) && !$rose(stat_o[0])));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !xfer_ack_i) |=> ($stable(src_ptr) && $stable(dst_ptr) && $stable(rem)));
endmodule

bind dma_chan dma_chan_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_rdata_o(reg_rdata_o), .xfer_req_o(xfer_req_o), .xfer_bytes_o(xfer_bytes_o),
  .xfer_ack_i(xfer_ack_i), .src_err_i(src_err_i), .dst_err_i(dst_err_i),
  .busy_o(busy_o), .stat_o(stat_o), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
  .rem(rem), .size16_q(size16_q)
);

// File: tb/dma_chan_tb.sv
module dma_chan_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [23:0] reg_wdata_i = '0;
  logic [23:0] reg_rdata_o;
  logic        xfer_req_o;
  logic [1:0]  xfer_bytes_o;
  logic        phase_wr_i = 1'b0;
  logic [23:0] bus_addr_o;
  logic [2:0]  bus_fc_o;
  logic        xfer_ack_i = 1'b0;
  logic        src_err_i = 1'b0;
  logic        dst_err_i = 1'b0;
  logic        ext_done_i = 1'b0;
  logic        busy_o;
  logic [3:0]  stat_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  dma_chan dut_i (.*);

  typedef struct packed {
    logic [23:0] src;
    logic [23:0] dst;
    logic [15:0] cnt;
    logic [3:0]  mode;   // {size16, dst_inc, src_inc, 0}
    logic [23:0] esrc;
    logic [23:0] edst;
    logic [16:0] nxf;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{24'h000100, 24'h000200, 16'd4, 4'hE, 24'h000104, 24'h000204, 17'd2},
    '{24'h000101, 24'h000200, 16'd3, 4'hE, 24'h000104, 24'h000203, 17'd3},
    '{24'h000100, 24'h000300, 16'd5, 4'hA, 24'h000105, 24'h000300, 17'd3},
    '{24'hFFFFFE, 24'h000010, 16'd3, 4'h6, 24'h000001, 24'h000013, 17'd3},
    '{24'hFFFFFE, 24'h000020, 16'd2, 4'hE, 24'h000000, 24'h000022, 17'd1},
    '{24'h000400, 24'h000501, 16'd4, 4'hE, 24'h000404, 24'h000505, 17'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic setup(input logic [23:0] s, input logic [23:0] d,
                       input logic [15:0] c, input logic [3:0] m);
    wr(3'd1, s);
    wr(3'd2, d);
    wr(3'd3, {8'h0, c});
    wr(3'd0, {20'h0, m | 4'h1});
  endtask

  // serves requests; err_at / edone_at pick a transfer index, -1 for none
  task automatic engine(input int err_at, input bit err_dst, input int edone_at,
                        output int nx, output int nb);
    nx = 0; nb = 0;
    while (busy_o && nx < 70000) begin
      if (xfer_req_o) begin
        if (nx == err_at) begin
          if (err_dst) dst_err_i = 1'b1; else src_err_i = 1'b1;
        end else begin
          xfer_ack_i = 1'b1;
          nb += int'(xfer_bytes_o);
          if (nx == edone_at) ext_done_i = 1'b1;
        end
        nx++;
      end
      @(negedge clk_i);
      xfer_ack_i = 1'b0; src_err_i = 1'b0; dst_err_i = 1'b0; ext_done_i = 1'b0;
    end
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 200000 && !finished) begin
        finished = 1'b1;
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=<200000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [23:0] r;
    int nx, nb;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R12 reset state
    chk("R12 busy", busy_o, 0);
    chk("R12 req", xfer_req_o, 0);
    chk("R12 stat", stat_o, 0);
    rd(3'd3, r); chk("R12 cnt", r, 0);
    rd(3'd1, r); chk("R12 src", r, 0);

    // R6 function codes: src [2:0], dst [6:4]
    wr(3'd4, 24'h53);
    rd(3'd4, r); chk("R6 fc", r, 24'h53);
    phase_wr_i = 1'b0; #1; chk("R6 fc rd", bus_fc_o, 3);
    phase_wr_i = 1'b1; #1; chk("R6 fc wr", bus_fc_o, 5);
    wr(3'd4, 24'h07);
    rd(3'd4, r); chk("R6 fc 111 kept", r, 24'h03);
    phase_wr_i = 1'b0;

    // table walk: R1 R2 R3 R5
    for (int i = 0; i < NV; i++) begin
      setup(VEC[i].src, VEC[i].dst, VEC[i].cnt, VEC[i].mode);
      chk("R5 busy", busy_o, 1);
      phase_wr_i = 1'b0; #1; chk("R6 rd addr", bus_addr_o, VEC[i].src);
      phase_wr_i = 1'b1; #1; chk("R6 wr addr", bus_addr_o, VEC[i].dst);
      phase_wr_i = 1'b0;
      engine(-1, 1'b0, -1, nx, nb);
      chk("R2 transfers", nx, VEC[i].nxf);
      chk("R3 bytes", nb, VEC[i].cnt);
      rd(3'd1, r); chk("R1 src", r, VEC[i].esrc);
      rd(3'd2, r); chk("R1 dst", r, VEC[i].edst);
      rd(3'd3, r); chk("R3 cnt zero", r, 0);
      chk("R5 idle", busy_o, 0);
      chk("R5 done", stat_o, 4'h1);
      wr(3'd5, 24'h1);
      chk("R7 clear done", stat_o, 0);
    end

    // R4 count 0 means 65536
    setup(24'h000000, 24'h100000, 16'd0, 4'hE);
    engine(-1, 1'b0, -1, nx, nb);
    chk("R4 transfers", nx, 32768);
    chk("R4 bytes", nb, 65536);
    rd(3'd1, r); chk("R4 src", r, 24'h010000);
    rd(3'd2, r); chk("R4 dst", r, 24'h110000);
    wr(3'd5, 24'h1);

    // R9 source error on second transfer
    setup(24'h000800, 24'h000900, 16'd6, 4'hE);
    engine(1, 1'b0, -1, nx, nb);
    chk("R9 idle", busy_o, 0);
    chk("R9 stat BES", stat_o, 4'h4);
    rd(3'd1, r); chk("R9 src held", r, 24'h000802);
    rd(3'd2, r); chk("R9 dst held", r, 24'h000902);
    rd(3'd3, r); chk("R9 cnt held", r, 4);
    wr(3'd5, 24'h0);
    chk("R7 write zero keeps", stat_o, 4'h4);

    // R9 destination error at first transfer, stacks with BES
    setup(24'h000A00, 24'h000B00, 16'd4, 4'hE);
    engine(0, 1'b1, -1, nx, nb);
    chk("R9 stat BED", stat_o, 4'h6);
    rd(3'd1, r); chk("R9 src first", r, 24'h000A00);
    rd(3'd5, r); chk("R7 rsvd zero", r, 24'h000006);
    wr(3'd5, 24'h6);
    chk("R7 multi clear", stat_o, 0);

    // R8 error and clear in the same cycle
    setup(24'h000100, 24'h000200, 16'd4, 4'hE);
    src_err_i = 1'b1;
    reg_we_i = 1'b1; reg_addr_i = 3'd5; reg_wdata_i = 24'hF;
    @(negedge clk_i);
    src_err_i = 1'b0; reg_we_i = 1'b0;
    chk("R8 set wins", stat_o, 4'h4);
    chk("R8 stopped", busy_o, 0);
    wr(3'd5, 24'h4);

    // R10 reloads while busy are ignored
    setup(24'h000100, 24'h000200, 16'd4, 4'hE);
    wr(3'd1, 24'h000ABC);
    wr(3'd3, 24'h000050);
    wr(3'd0, 24'h000001);
    rd(3'd0, r); chk("R10 mode kept", r, 24'h00000F);
    engine(-1, 1'b0, -1, nx, nb);
    chk("R10 transfers", nx, 2);
    rd(3'd1, r); chk("R10 src", r, 24'h000104);
    wr(3'd5, 24'h1);

    // R11 early termination
    setup(24'h000100, 24'h000200, 16'd6, 4'hE);
    engine(-1, 1'b0, 0, nx, nb);
    chk("R11 transfers", nx, 1);
    chk("R11 stat DNS", stat_o, 4'h8);
    rd(3'd3, r); chk("R11 cnt", r, 4);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule